// File: doc/BRIEF.md
# Timed configuration-bit read controller

This block sits beside a CPU's program-memory load path and decides, for every load, whether the returned byte comes from flash or from the device's stored protection and configuration bits. Software arms it through a control-register write that carries two enable bits: one for reading configuration bits and one for self-programming. When both are set, a short read window opens. A load issued inside that window with the right pointer value returns the lock bits or the low fuse byte in place of flash data.

The window closes on its own. It closes after one use, after a load timeout of three cycles, or after a store timeout of four cycles when only the self-program bit is armed. While an EEPROM write is in progress, control writes are dropped and configuration reads are refused. Stored bits arrive as "programmed" flags, and the block inverts them so that a programmed bit reads as 0.

Top module: `cfgbit_read_ctrl`

## Requirements
- R1: After a control write with both enable bits set and `ee_busy` low, a load issued on clock 1, 2 or 3 after the write returns configuration bits on `ld_data` one clock after the load.
- R2: If the read-config bit is set and no load arrives on clocks 1 to 3 after the write, both enable bits are clear after clock 3, and a load on clock 4 returns `flash_rdata`.
- R3: A load while the read-config bit is set clears both enable bits on the same clock edge.
- R4: With only the self-program bit set, a store clears it on that edge. With no store, it stays set through clock 3 and is clear after clock 4.
- R5: Inside the window, pointer 0x0001 returns `{6'b111111, ~lock_prog[1], ~lock_prog[0]}` and pointer 0x0000 returns `~fuse_prog`. A programmed bit (flag 1) therefore reads as 0.
- R6: Inside the window, a load with any other pointer returns `flash_rdata` and still clears both enable bits.
- R7: While `ee_busy` is high, a control write has no effect on the enable bits.
- R8: Inside the window, a load made while `ee_busy` is high returns `flash_rdata` and clears both enable bits.
- R9: While both enable bits are not set, every load returns `flash_rdata`. `ld_data` changes only on an edge where `ld_req` is high.
- R10: With only the read-config bit set, loads return `flash_rdata`.
- R11: During and right after reset, both enable bits and `ld_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctl_wr | input | 1 | Control-register write strobe |
| ctl_cfg_rd | input | 1 | Written value of the read-config enable |
| ctl_spm_en | input | 1 | Written value of the self-program enable |
| ld_req | input | 1 | Program-memory load request |
| ld_addr | input | 16 | Load pointer |
| st_req | input | 1 | Store-to-program-memory request |
| ee_busy | input | 1 | EEPROM write in progress |
| lock_prog | input | 2 | Lock bits, 1 = programmed |
| fuse_prog | input | 8 | Low fuse byte, 1 = programmed |
| flash_rdata | input | 8 | Flash byte at the load pointer |
| ld_data | output | 8 | Load result, registered |
| cfg_rd_en | output | 1 | Current read-config enable bit |
| spm_en | output | 1 | Current self-program enable bit |

## Verification
A timeout counter that is off by one shows up as flash data returned on clock 3 or configuration bits returned on clock 4. It can also show up as an enable bit still visible on `cfg_rd_en`/`spm_en` one clock past its deadline. Both are seen within four clocks of the arming write. A select that is wrong in its inversion, lock padding or pointer decode is wrong on `ld_data` on the clock right after the load. The random part varies the load delay around the three-cycle edge, the pointer, and the busy flag against bench-computed results.

// File: rtl/cfgrd_pkg.sv
package cfgrd_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int LOCK_W = 2;
  localparam logic [ADDR_W-1:0] PTR_FUSE_LO = 16'h0000;
  localparam logic [ADDR_W-1:0] PTR_LOCK    = 16'h0001;

  typedef enum logic [1:0] {
    SRC_FLASH = 2'd0,
    SRC_LOCK  = 2'd1,
    SRC_FUSE  = 2'd2
  } src_e;
endpackage

// File: rtl/cfgrd_window.sv
module cfgrd_window #(
  parameter int LD_WIN = 3,
  parameter int ST_WIN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  logic ctl_rd,
  input  logic ctl_sp,
  input  logic ee_busy,
  input  logic ld_req,
  input  logic st_req,
  output logic rd_q,
  output logic sp_q
);
  localparam int CNT_W = $clog2(ST_WIN + 1);
  localparam logic [CNT_W-1:0] LIM_LD = CNT_W'(LD_WIN - 1);
  localparam logic [CNT_W-1:0] LIM_ST = CNT_W'(ST_WIN - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rd_d, sp_d;
  logic             wr_ok, used, expired, armed;

  assign wr_ok   = ctl_wr & ~ee_busy;
  assign armed   = rd_q | sp_q;
  assign used    = (rd_q & ld_req) | (sp_q & st_req);
  assign expired = rd_q ? (cnt_q == LIM_LD) : (cnt_q == LIM_ST);

  always_comb begin
    rd_d  = rd_q;
    sp_d  = sp_q;
    cnt_d = cnt_q;
    if (wr_ok) begin
      rd_d  = ctl_rd;
      sp_d  = ctl_sp;
      cnt_d = '0;
    end else if (armed) begin
      if (used || expired) begin
        rd_d  = 1'b0;
        sp_d  = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= 1'b0;
      sp_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      sp_q  <= sp_d;
      cnt_q <= cnt_d;
    end
  end

  // R7: a write during an EEPROM write leaves idle bits idle
  p_ee_write_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ee_busy && !rd_q && !sp_q) |=> (!rd_q && !sp_q));

  // R3: any load under the read-config bit consumes the arming
  p_load_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_q && ld_req && !ctl_wr) |=> (!rd_q && !sp_q));

  // R4: a store under the self-program bit consumes the arming
  p_store_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_q && st_req && !ctl_wr) |=> (!rd_q && !sp_q));

  // R2: counter never runs past the longest window
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM_ST);

  // R2: the read-config bit never outlives the load window
  p_rd_short_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_q |-> (cnt_q <= LIM_LD));
endmodule

// File: rtl/cfgrd_select.sv
module cfgrd_select
  import cfgrd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_open,
  input  logic              ee_busy,
  input  logic              ld_req,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [LOCK_W-1:0] lock_prog,
  input  logic [DATA_W-1:0] fuse_prog,
  input  logic [DATA_W-1:0] flash_rdata,
  output logic [DATA_W-1:0] ld_data
);
  src_e              src;
  logic [DATA_W-1:0] res_d, ld_data_d;

  always_comb begin
    src = SRC_FLASH;
    if (win_open && !ee_busy) begin
      if (ld_addr == PTR_LOCK)         src = SRC_LOCK;
      else if (ld_addr == PTR_FUSE_LO) src = SRC_FUSE;
    end
  end

  always_comb begin
    unique case (src)
      SRC_LOCK: res_d = {{(DATA_W-LOCK_W){1'b1}}, ~lock_prog};
      SRC_FUSE: res_d = ~fuse_prog;
      default:  res_d = flash_rdata;
    endcase
  end

  assign ld_data_d = ld_req ? res_d : ld_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ld_data <= '0;
    else        ld_data <= ld_data_d;
  end

  // R5: lock result pads its upper bits with ones
  p_lock_pad_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req && win_open && !ee_busy && ld_addr == PTR_LOCK)
      |=> (ld_data[DATA_W-1:LOCK_W] == '1));

  // R9: outside the window a load passes flash through
  p_flash_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req && !win_open) |=> (ld_data == $past(flash_rdata)));

  // R9: result holds without a load
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_req |=> $stable(ld_data));
endmodule

// File: rtl/cfgbit_read_ctrl.sv
module cfgbit_read_ctrl
  import cfgrd_pkg::*;
#(
  parameter int LD_WIN = 3,
  parameter int ST_WIN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic              ctl_cfg_rd,
  input  logic              ctl_spm_en,
  input  logic              ld_req,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              st_req,
  input  logic              ee_busy,
  input  logic [LOCK_W-1:0] lock_prog,
  input  logic [DATA_W-1:0] fuse_prog,
  input  logic [DATA_W-1:0] flash_rdata,
  output logic [DATA_W-1:0] ld_data,
  output logic              cfg_rd_en,
  output logic              spm_en
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  cfgrd_window #(.LD_WIN(LD_WIN), .ST_WIN(ST_WIN)) u_window (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .ctl_wr  (ctl_wr),
    .ctl_rd  (ctl_cfg_rd),
    .ctl_sp  (ctl_spm_en),
    .ee_busy (ee_busy),
    .ld_req  (ld_req),
    .st_req  (st_req),
    .rd_q    (cfg_rd_en),
    .sp_q    (spm_en)
  );

  cfgrd_select u_select (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .win_open    (cfg_rd_en & spm_en),
    .ee_busy     (ee_busy),
    .ld_req      (ld_req),
    .ld_addr     (ld_addr),
    .lock_prog   (lock_prog),
    .fuse_prog   (fuse_prog),
    .flash_rdata (flash_rdata),
    .ld_data     (ld_data)
  );

  // R11: enables idle while reset is held internally
  p_reset_idle_r11: assert property (@(posedge clk)
    !rst_int_n |=> (!cfg_rd_en && !spm_en && ld_data == '0));
endmodule

// File: tb/cfgbit_read_ctrl_tb.sv
module cfgbit_read_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_wr, ctl_cfg_rd, ctl_spm_en, ld_req, st_req, ee_busy;
  logic [15:0] ld_addr;
  logic [1:0]  lock_prog;
  logic [7:0]  fuse_prog, flash_rdata, ld_data;
  logic        cfg_rd_en, spm_en;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10ns clk = ~clk;

  cfgbit_read_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_cfg_rd(ctl_cfg_rd),
    .ctl_spm_en(ctl_spm_en), .ld_req(ld_req), .ld_addr(ld_addr),
    .st_req(st_req), .ee_busy(ee_busy), .lock_prog(lock_prog),
    .fuse_prog(fuse_prog), .flash_rdata(flash_rdata), .ld_data(ld_data),
    .cfg_rd_en(cfg_rd_en), .spm_en(spm_en)
  );

  function automatic logic [7:0] exp_load(input bit open, input bit busy,
      input logic [15:0] a, input logic [1:0] lk, input logic [7:0] fz,
      input logic [7:0] fl);
    if (open && !busy && a == 16'h0001) return {6'h3F, ~lk};
    if (open && !busy && a == 16'h0000) return ~fz;
    return fl;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic arm(input logic rd, input logic sp);
    ctl_wr = 1'b1; ctl_cfg_rd = rd; ctl_spm_en = sp;
    tick();
    ctl_wr = 1'b0; ctl_cfg_rd = 1'b0; ctl_spm_en = 1'b0;
  endtask

  task automatic load(input logic [15:0] a);
    ld_req = 1'b1; ld_addr = a;
    tick();
    ld_req = 1'b0;
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(20ns * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; ctl_wr = 0; ctl_cfg_rd = 0; ctl_spm_en = 0;
    ld_req = 0; st_req = 0; ee_busy = 0; ld_addr = '0;
    lock_prog = 2'b01; fuse_prog = 8'hA5; flash_rdata = 8'h3C;
    @(negedge clk); @(negedge clk);
    chk("R11 ld_data", ld_data, 8'h00);
    chk("R11 enables", {6'd0, cfg_rd_en, spm_en}, 8'h00);
    rst_n = 1'b1;
    repeat (3) tick();
    chk("R11 after release", {6'd0, cfg_rd_en, spm_en}, 8'h00);

    // R5 lock read, programmed bit reads 0
    arm(1, 1);
    chk("R1 armed", {6'd0, cfg_rd_en, spm_en}, 8'h03);
    load(16'h0001);
    chk("R5 lock", ld_data, 8'hFE);
    chk("R3 cleared", {6'd0, cfg_rd_en, spm_en}, 8'h00);

    // R5 fuse on clock 3 (R1 edge)
    arm(1, 1); tick(); tick();
    load(16'h0000);
    chk("R1 R5 fuse clock3", ld_data, 8'h5A);

    // R2 clock 4 returns flash
    arm(1, 1); tick(); tick(); tick();
    chk("R2 timeout clear", {6'd0, cfg_rd_en, spm_en}, 8'h00);
    load(16'h0000);
    chk("R2 flash after window", ld_data, 8'h3C);

    // R6 other pointer
    flash_rdata = 8'h77;
    arm(1, 1);
    load(16'h0002);
    chk("R6 other ptr", ld_data, 8'h77);
    chk("R6 cleared", {6'd0, cfg_rd_en, spm_en}, 8'h00);

    // R4 self-program only
    arm(0, 1); tick(); tick(); tick();
    chk("R4 held clock3", {6'd0, cfg_rd_en, spm_en}, 8'h01);
    tick();
    chk("R4 cleared clock4", {6'd0, cfg_rd_en, spm_en}, 8'h00);
    arm(0, 1); st_req = 1'b1; tick(); st_req = 1'b0;
    chk("R4 store clears", {6'd0, cfg_rd_en, spm_en}, 8'h00);

    // R10 read-config only
    flash_rdata = 8'h19;
    arm(1, 0);
    load(16'h0001);
    chk("R10 flash", ld_data, 8'h19);

    // R7 write while busy
    ee_busy = 1'b1;
    arm(1, 1);
    chk("R7 write ignored", {6'd0, cfg_rd_en, spm_en}, 8'h00);
    ee_busy = 1'b0;
    load(16'h0000);
    chk("R7 no window", ld_data, 8'h19);

    // R8 busy during load
    arm(1, 1);
    ee_busy = 1'b1;
    load(16'h0001);
    ee_busy = 1'b0;
    chk("R8 refused", ld_data, 8'h19);
    chk("R8 cleared", {6'd0, cfg_rd_en, spm_en}, 8'h00);

    // R9 hold without load
    flash_rdata = 8'hC3;
    tick();
    chk("R9 hold", ld_data, 8'h19);
    load(16'h0001);
    chk("R9 flash idle", ld_data, 8'hC3);

    // random: delay around the window edge, pointer, busy
    for (int i = 0; i < 60; i++) begin
      int d;
      bit busy;
      logic [15:0] a;
      logic [7:0] e;
      d = $urandom % 5;
      busy = ($urandom % 4) == 0;
      case ($urandom % 4)
        0: a = 16'h0000;
        1: a = 16'h0001;
        2: a = 16'h0002;
        default: a = 16'h0100 | 16'($urandom);
      endcase
      lock_prog = 2'($urandom);
      fuse_prog = 8'($urandom);
      flash_rdata = 8'($urandom);
      arm(1, 1);
      for (int k = 0; k < d; k++) tick();
      e = exp_load(d <= 2, busy, a, lock_prog, fuse_prog, flash_rdata);
      ee_busy = busy;
      load(a);
      ee_busy = 1'b0;
      chk("R1 R2 R5 R6 R8 random load", ld_data, e);
      chk("R3 random clear", {6'd0, cfg_rd_en, spm_en}, 8'h00);
    end

    done = 1;
    finish_run();
  end
endmodule